// File: doc/BRIEF.md
# Bit-Serial Word Adder

This block adds two unsigned words of `WORD_BITS` bits that arrive one bit per clock, least-significant bit first. It holds a single full-adder cell and one carry flip-flop. Each clock with the input strobe high, the cell combines the two operand bits with the stored carry. The sum bit leaves through a register, and the carry out is stored for the next bit of the same word. The upstream serialiser supplies the operand bits, the strobe and an optional start-of-word marker. The downstream deserialiser collects the sum bits and is told which output bit closes a word. On that bit it also receives the carry out of the word's top position.

An internal position counter tracks where each word ends. On the top bit position the stored carry is dropped instead of being passed into the next word, so words can follow each other on consecutive clocks with no idle cycle. A start marker restarts the position count and forces the carry-in to zero at any time, which also abandons a partly sent word. Clocks with the strobe low hold the carry and the position unchanged, so a word may be sent with gaps in it.

Top module: `bitser_word_adder`

## Requirements
- R1: A synchronous active-high reset clears the stored carry and the position counter and drives all outputs to 0. The first word after reset starts at bit position 0 with carry-in 0, even without a start marker.
- R2: `res_valid` equals the value `bit_valid` had one clock earlier.
- R3: For every accepted bit, `res_sum` one clock later equals `op_a ^ op_b ^ cin`. Here `cin` is the carry out of the previous accepted bit of the same word, or 0 on the word's first bit. The `WORD_BITS` sum bits of a word, LSB first, form (A + B) mod 2^WORD_BITS.
- R4: A clock with `bit_valid` low leaves the stored carry and the bit position unchanged, so the next accepted bit continues the same word.
- R5: An accepted bit with `bit_first` high is taken as position 0 with carry-in forced to 0, whatever state came before.
- R6: `res_last` is 1 exactly on the output bit whose position is `WORD_BITS-1`. Positions count accepted bits from 0 since the last start marker, the last completed word, or reset.
- R7: `res_carry` is 1 only on an output bit with `res_last` high, and there it equals the carry out of the top bit, that is (A + B) >> WORD_BITS.
- R8: After the top bit of a word the stored carry is cleared and the position returns to 0. The next word can start on the following clock, with or without a start marker, and sees carry-in 0.
- R9: While `res_valid` is 0, `res_sum`, `res_last` and `res_carry` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Operand bits on this clock are to be added |
| bit_first | input | 1 | This bit is position 0 of a new word |
| op_a | input | 1 | Current bit of operand A, LSB first |
| op_b | input | 1 | Current bit of operand B, LSB first |
| res_valid | output | 1 | Sum bit on this clock is valid |
| res_sum | output | 1 | Sum bit, one clock after its operand bits |
| res_last | output | 1 | This sum bit is the top bit of its word |
| res_carry | output | 1 | Carry out of the word, meaningful with res_last |

## Verification
A wrong stored carry shows up on the very next accepted bit of the same word: that sum bit is inverted, and the error may propagate through the rest of the word and into `res_carry`. A carry that is not cleared at a word boundary corrupts bit 0 of the following word, one clock after that bit enters. A wrong position count moves `res_last`, and with it the word's carry report, away from the `WORD_BITS`-th output bit. The reference model therefore compares every output on every clock, and the reassembled words are checked against the arithmetic sum, so all of these faults are caught within one word.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    // Operand slice presented to the full-adder cell.
    typedef struct packed {
        logic a;
        logic b;
        logic cin;
    } fa_in_t;

    // Result of one full-adder evaluation.
    typedef struct packed {
        logic sum;
        logic cout;
    } fa_out_t;

    // Registered output beat of the adder.
    typedef struct packed {
        logic valid;
        logic sum;
        logic last;
        logic carry;
    } ser_out_t;

    localparam ser_out_t SER_OUT_IDLE = '{valid: 1'b0, sum: 1'b0, last: 1'b0, carry: 1'b0};

    function automatic fa_out_t full_add(input fa_in_t x);
        fa_out_t r;
        r.sum  = x.a ^ x.b ^ x.cin;
        r.cout = (x.a & x.b) | (x.a & x.cin) | (x.b & x.cin);
        return r;
    endfunction

    function automatic int unsigned pos_width(input int unsigned w);
        return (w <= 2) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/bsa_full_adder.sv
module bsa_full_adder
    import bsa_pkg::*;
#(
    parameter int unsigned CELL_STYLE = 0   // 0: sum/majority form, 1: two half adders
) (
    input  fa_in_t  fa_in,
    output fa_out_t fa_out
);

    generate
        if (CELL_STYLE == 0) begin : g_flat
            always_comb fa_out = full_add(fa_in);
        end else begin : g_halves
            logic half_sum;
            logic half_gen;
            always_comb begin
                half_sum      = fa_in.a ^ fa_in.b;
                half_gen      = fa_in.a & fa_in.b;
                fa_out.sum    = half_sum ^ fa_in.cin;
                fa_out.cout   = half_gen | (half_sum & fa_in.cin);
            end
        end
    endgenerate

endmodule

// File: rtl/bsa_word_tracker.sv
module bsa_word_tracker
    import bsa_pkg::*;
#(
    parameter int unsigned WORD_BITS = 8,
    localparam int unsigned POS_W = pos_width(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             first,
    output logic [POS_W-1:0] pos_now,
    output logic             top_bit
);

    localparam logic [POS_W-1:0] POS_TOP = POS_W'(WORD_BITS - 1);

    logic [POS_W-1:0] pos_q;

    always_comb begin
        pos_now = first ? '0 : pos_q;
        top_bit = (pos_now == POS_TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (adv) begin
            if (top_bit) pos_q <= '0;
            else         pos_q <= pos_now + POS_W'(1);
        end
    end

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        pos_q <= POS_TOP); // R6
    AST_POS_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pos_q)); // R4
    AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && top_bit) |=> (pos_q == '0)); // R8
    AST_POS_FIRST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (adv && first && !top_bit) |=> (pos_q == POS_W'(1))); // R5

endmodule

// File: rtl/bsa_carry_reg.sv
module bsa_carry_reg (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic first,
    input  logic top_bit,
    input  logic cout,
    output logic cin
);

    logic carry_q;

    always_comb cin = first ? 1'b0 : carry_q;

    always_ff @(posedge clk) begin
        if (rst)          carry_q <= 1'b0;
        else if (adv)     carry_q <= top_bit ? 1'b0 : cout;
    end

    AST_CARRY_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(carry_q)); // R4
    AST_CARRY_SQUASH: assert property (@(posedge clk) disable iff (rst)
        (adv && top_bit) |=> !carry_q); // R8
    AST_CARRY_FIRST_ZERO: assert property (@(posedge clk) disable iff (rst)
        (adv && first) |-> !cin); // R5

endmodule

// File: rtl/bitser_word_adder.sv
module bitser_word_adder
    import bsa_pkg::*;
#(
    parameter int unsigned WORD_BITS  = 8,
    parameter int unsigned CELL_STYLE = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_first,
    input  logic op_a,
    input  logic op_b,
    output logic res_valid,
    output logic res_sum,
    output logic res_last,
    output logic res_carry
);

    localparam int unsigned POS_W = pos_width(WORD_BITS);

    logic [POS_W-1:0] pos_now;
    logic             top_bit;
    logic             cin;
    fa_in_t           cell_in;
    fa_out_t          cell_out;
    ser_out_t         out_q;

    bsa_word_tracker #(.WORD_BITS(WORD_BITS)) u_tracker (
        .clk     (clk),
        .rst     (rst),
        .adv     (bit_valid),
        .first   (bit_first),
        .pos_now (pos_now),
        .top_bit (top_bit)
    );

    bsa_carry_reg u_carry (
        .clk     (clk),
        .rst     (rst),
        .adv     (bit_valid),
        .first   (bit_first),
        .top_bit (top_bit),
        .cout    (cell_out.cout),
        .cin     (cin)
    );

    always_comb begin
        cell_in.a   = op_a;
        cell_in.b   = op_b;
        cell_in.cin = cin;
    end

    bsa_full_adder #(.CELL_STYLE(CELL_STYLE)) u_cell (
        .fa_in  (cell_in),
        .fa_out (cell_out)
    );

    always_ff @(posedge clk) begin
        if (rst || !bit_valid) begin
            out_q <= SER_OUT_IDLE;
        end else begin
            out_q.valid <= 1'b1;
            out_q.sum   <= cell_out.sum;
            out_q.last  <= top_bit;
            out_q.carry <= top_bit & cell_out.cout;
        end
    end

    always_comb begin
        res_valid = out_q.valid;
        res_sum   = out_q.sum;
        res_last  = out_q.last;
        res_carry = out_q.carry;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> res_valid); // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> !res_valid); // R2
    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_sum && !res_last && !res_carry)); // R9
    AST_CARRY_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        res_carry |-> res_last); // R7
    AST_POS_UNUSED_GUARD: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bit_first) |-> (pos_now == '0)); // R5

endmodule

// File: tb/bitser_word_adder_test.sv
module bitser_word_adder_test;

    localparam int W      = 8;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0, bit_first = 1'b0, op_a = 1'b0, op_b = 1'b0;
    logic res_valid, res_sum, res_last, res_carry;

    int checks = 0;
    int errors = 0;

    // reference model state
    int carry_m = 0;
    int pos_m   = 0;
    int e_valid, e_sum, e_last, e_carry, e_pos;
    string phase = "R3";

    // word-level collector
    logic [W-1:0] acc;
    int exp_sum_q[$];
    int exp_cy_q[$];

    bitser_word_adder #(.WORD_BITS(W)) uut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_first(bit_first),
        .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_sum(res_sum),
        .res_last(res_last), .res_carry(res_carry)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (phase %s)", req, act, exp, phase);
        end
    endtask

    // Drive one clock of input (called at negedge), compare at next negedge.
    task automatic step(input bit v, input bit f, input bit a, input bit b);
        bit_valid = v; bit_first = f; op_a = a; op_b = b;
        if (v) begin
            int cin, s, co;
            int p;
            cin = f ? 0 : carry_m;
            p   = f ? 0 : pos_m;
            s   = a ^ b ^ cin;
            co  = (a + b + cin) >= 2;
            e_valid = 1; e_sum = s; e_pos = p;
            e_last  = (p == W-1);
            e_carry = e_last ? co : 0;
            carry_m = e_last ? 0 : co;
            pos_m   = e_last ? 0 : p + 1;
        end else begin
            e_valid = 0; e_sum = 0; e_last = 0; e_carry = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check("R2", res_valid, e_valid);
        check("R3", res_sum, e_sum);
        check("R6", res_last, e_last);
        check("R7", res_carry, e_carry);
        if (!e_valid) check("R9", {res_sum, res_last, res_carry}, 0);
        if (res_valid) begin
            acc[e_pos] = res_sum;
            if (res_last) begin
                if (exp_sum_q.size() > 0) begin
                    check("R3", acc, exp_sum_q.pop_front());
                    check("R7", res_carry, exp_cy_q.pop_front());
                end
            end
        end
        bit_valid = 0; bit_first = 0;
    endtask

    task automatic send_word(input int A, input int B, input bit mark, input int gap_pct);
        int sum;
        sum = A + B;
        exp_sum_q.push_back(sum % (1 << W));
        exp_cy_q.push_back(sum >> W);
        for (int i = 0; i < W; i++) begin
            while (gap_pct > 0 && ($urandom % 100) < gap_pct)
                step(0, 0, $urandom % 2, $urandom % 2);
            step(1, mark && (i == 0), A[i], B[i]);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL R1 watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        phase = "R1";
        check("R1", {res_valid, res_sum, res_last, res_carry}, 0);
        rst = 1'b0;
        // R1: first word after reset without a marker
        send_word(8'hFF, 8'h01, 0, 0);
        // R8: all-ones boundary, back-to-back words, no marker
        phase = "R8";
        send_word(8'hFF, 8'hFF, 0, 0);
        send_word(8'h00, 8'h00, 0, 0);
        send_word(8'hFF, 8'h01, 1, 0);
        send_word(8'h01, 8'h00, 0, 0);
        // R4: gaps inside words
        phase = "R4";
        for (int k = 0; k < 40; k++) send_word($urandom % 256, $urandom % 256, k % 2, 40);
        // R5: abandon a partial word with a carry pending, then restart with a marker
        phase = "R5";
        for (int k = 0; k < 20; k++) begin
            int n;
            n = 1 + ($urandom % (W - 1));
            for (int i = 0; i < n; i++) step(1, i == 0, 1, 1);
            send_word($urandom % 256, $urandom % 256, 1, 0);
        end
        // R3: random back-to-back streaming with markers
        phase = "R3";
        for (int k = 0; k < 150; k++) send_word($urandom % 256, $urandom % 256, 1, 0);
        // R9: trailing idle cycles
        phase = "R9";
        repeat (4) step(0, 0, 1, 1);
        check("R3", exp_sum_q.size(), 0);
        // R1: reset mid-word clears state
        phase = "R1";
        step(1, 1, 1, 1);
        step(1, 0, 1, 1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1", {res_valid, res_sum, res_last, res_carry}, 0);
        carry_m = 0; pos_m = 0;
        send_word(8'h0F, 8'hF1, 0, 0);
        check("R1", exp_sum_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule